// File: doc/BRIEF.md
# Fourth-Order Plesiochronous Frame Alignment Monitor

This block watches a recovered 139.264 Mbit/s line stream, one bit per clock, and locks onto its frame structure. The frame is 2928 bits long and opens with a fixed 12-bit alignment word. A search state looks for that word at any bit offset. A confirmation state checks that the word comes back at the frame spacing. An aligned state then keeps checking it at every frame.

While the stream is aligned, the bit that follows the alignment word is read as the far-end alarm. Each errored alignment word seen while aligned is counted in a saturating performance counter. A loss of alignment and a far-end alarm each set a sticky interrupt request, and each request can only be set when its enable is high. When the receive path replaces the line with AIS, an input holds the whole monitor idle.

Top module: `fam_monitor`

## Requirements
- R1: After a synchronous active-low reset, `in_frame`, `rai_status`, `lof_sticky`, `irq_lof`, `irq_rai` and `err_cnt` are all 0.
- R2: A frame is 2928 bits. Frame bits 1 to 12, with bit 1 first on the line, carry the alignment word 111110100000. While searching, the monitor finds this word at any bit offset.
- R3: `in_frame` goes to 1 at the third consecutive correct alignment word at frame spacing. The word found by the search counts as the first. If a word is wrong during confirmation, the search starts again and `in_frame` stays 0.
- R4: While aligned, alignment is lost (`in_frame` goes to 0) at the fourth consecutive errored alignment word. A correct word resets the run of errors.
- R5: While aligned, frame bit 13 is sampled once per frame and shown on `rai_status` (1 means far-end alarm). While not aligned, `rai_status` is 0.
- R6: `irq_rai` is set when a sampled bit 13 is 1 and `rai_ien` is 1. It is never set while `rai_ien` is 0. A `flag_clr` pulse clears it.
- R7: A loss of alignment always sets `lof_sticky`. It sets `irq_lof` only when `lof_ien` is 1. A `flag_clr` pulse clears both.
- R8: `err_cnt` rises by one for each errored alignment word seen while aligned, including the word that causes the loss. It does not change while not aligned.
- R9: `err_cnt` is CNT_W bits wide (16 by default) and saturates at all ones. An `err_clr` pulse sets it to 0, and the clear wins over a same-cycle increment.
- R10: While `mon_dis` is 1, `in_frame` is 0 and the monitor neither searches nor counts errors, samples the alarm or sets any flag. After release it begins a fresh search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Received line bit, one per clock |
| mon_dis | input | 1 | Holds the monitor idle while line AIS is generated |
| lof_ien | input | 1 | Enables setting of the loss-of-frame interrupt |
| rai_ien | input | 1 | Enables setting of the far-end alarm interrupt |
| flag_clr | input | 1 | Clears sticky flags and interrupt requests |
| err_clr | input | 1 | Clears the framing error counter |
| in_frame | output | 1 | Alignment held |
| rai_status | output | 1 | Last sampled far-end alarm bit |
| lof_sticky | output | 1 | Sticky loss-of-alignment flag |
| irq_lof | output | 1 | Loss-of-alignment interrupt request |
| irq_rai | output | 1 | Far-end alarm interrupt request |
| err_cnt | output | CNT_W | Saturating framing error count |

## Verification
Counter saturation is the hardest state to reach. Each error costs a whole frame, and four errors in a row drop alignment. The bench therefore narrows the counter width and sends errored words in runs of three, each followed by one correct word, so that alignment is held until the counter pins at all ones. A second hard case is a wrong word during confirmation. The bench reaches it by corrupting the second frame after reset and checking that a full three-word confirmation is needed again.

// File: rtl/fam_pkg.sv
// Shared types and constants for the frame alignment monitor.
package fam_pkg;
    // Alignment state: searching, confirming a candidate, or locked.
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_SYNC    = 2'd2
    } fam_state_e;

    // Default alignment word, bit 1 of the frame is the MSB.
    localparam int unsigned FAW_BITS = 12;
    localparam logic [FAW_BITS-1:0] FAW_DEFAULT = 12'b1111_1010_0000;
endpackage

// File: rtl/fam_faw_detect.sv
// Alignment word detector.
// Shifts the line bits into a window and flags the cycle in which the
// current bit completes the alignment word. Assumes bit 1 arrives first.
module fam_faw_detect #(
    parameter int unsigned        FAW_LEN  = 12,
    parameter logic [FAW_LEN-1:0] FAW_WORD = 12'b1111_1010_0000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    output logic match
);
    logic [FAW_LEN-1:0] win_q;
    logic [FAW_LEN-1:0] win_nxt;

    // Window including the bit presented in this cycle.
    always_comb win_nxt = {win_q[FAW_LEN-2:0], rx_bit};

    // Holds the last FAW_LEN-1 received bits.
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_nxt;
    end

    // Word complete in this cycle.
    always_comb match = (win_nxt == FAW_WORD);
endmodule

// File: rtl/fam_align_fsm.sv
// Alignment state machine.
// Searches for the alignment word, confirms it at frame spacing, then
// keeps checking it. Emits one-cycle events for errored words, for loss
// and for the alarm bit slot. Assumes GAIN_WORDS >= 2 and LOSS_WORDS >= 1.
module fam_align_fsm
    import fam_pkg::*;
#(
    parameter int unsigned FRAME_LEN  = 2928,
    parameter int unsigned FAW_LEN    = 12,
    parameter int unsigned GAIN_WORDS = 3,
    parameter int unsigned LOSS_WORDS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mon_dis,
    input  logic match,
    output logic in_frame,
    output logic err_ev,
    output logic lost_ev,
    output logic alarm_ev
);
    localparam int unsigned PW = $clog2(FRAME_LEN);
    localparam int unsigned GW = $clog2(GAIN_WORDS + 1);
    localparam int unsigned BW = $clog2(LOSS_WORDS + 1);
    localparam logic [PW-1:0] POS_LAST  = PW'(FRAME_LEN - 1);
    localparam logic [PW-1:0] POS_FAW   = PW'(FAW_LEN - 1);
    localparam logic [PW-1:0] POS_ALARM = PW'(FAW_LEN);

    fam_state_e      state_q;
    logic [PW-1:0]   pos_q;
    logic [PW-1:0]   pos_nxt;
    logic [GW-1:0]   good_q;
    logic [BW-1:0]   bad_q;
    logic            at_faw;
    logic            at_alarm;

    // Bit position decode within the frame.
    always_comb begin
        pos_nxt  = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
        at_faw   = (pos_q == POS_FAW);
        at_alarm = (pos_q == POS_ALARM);
    end

    // Search, confirmation and maintenance of alignment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            pos_q   <= '0;
            good_q  <= '0;
            bad_q   <= '0;
        end else if (mon_dis) begin
            state_q <= ST_HUNT;
            good_q  <= '0;
            bad_q   <= '0;
        end else begin
            case (state_q)
                ST_HUNT: begin
                    if (match) begin
                        state_q <= ST_CONFIRM;
                        pos_q   <= POS_ALARM;
                        good_q  <= GW'(1);
                    end
                end
                ST_CONFIRM: begin
                    pos_q <= pos_nxt;
                    if (at_faw) begin
                        if (!match) begin
                            state_q <= ST_HUNT;
                        end else if (good_q == GW'(GAIN_WORDS - 1)) begin
                            state_q <= ST_SYNC;
                            bad_q   <= '0;
                        end else begin
                            good_q  <= good_q + 1'b1;
                        end
                    end
                end
                ST_SYNC: begin
                    pos_q <= pos_nxt;
                    if (at_faw) begin
                        if (match) begin
                            bad_q <= '0;
                        end else if (bad_q == BW'(LOSS_WORDS - 1)) begin
                            state_q <= ST_HUNT;
                            bad_q   <= '0;
                        end else begin
                            bad_q <= bad_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_HUNT;
            endcase
        end
    end

    // Event strobes toward the counter and the alarm flags.
    always_comb begin
        in_frame = (state_q == ST_SYNC);
        err_ev   = in_frame && !mon_dis && at_faw && !match;
        lost_ev  = err_ev && (bad_q == BW'(LOSS_WORDS - 1));
        alarm_ev = in_frame && !mon_dis && at_alarm;
    end

    // R4: a loss event leaves the aligned state on the next cycle.
    p_loss_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lost_ev |=> !in_frame);

    // R10: the disable input forces the search state.
    p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mon_dis |=> (state_q == ST_HUNT));

    // R3: alignment is only entered from confirmation.
    p_gain_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> ($past(state_q) == ST_CONFIRM));
endmodule

// File: rtl/fam_err_counter.sv
// Saturating framing error counter with clear.
// Assumes inc is a one-cycle strobe; clear has priority.
module fam_err_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Count up to all ones, clear on request.
    always_ff @(posedge clk) begin
        if (!rst_n)                     cnt <= '0;
        else if (clr)                   cnt <= '0;
        else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // R9: a full counter never wraps.
    p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX);

    // R9: a clear always empties the counter.
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
endmodule

// File: rtl/fam_alarm_flags.sv
// Far-end alarm status and sticky interrupt flags.
// Assumes alarm_ev and lost_ev are one-cycle strobes from the FSM.
// A setting event wins over a clear in the same cycle.
module fam_alarm_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic in_frame,
    input  logic alarm_ev,
    input  logic rx_bit,
    input  logic lost_ev,
    input  logic lof_ien,
    input  logic rai_ien,
    input  logic flag_clr,
    output logic rai_status,
    output logic lof_sticky,
    output logic irq_lof,
    output logic irq_rai
);
    // Latch the alarm bit once per frame while aligned.
    always_ff @(posedge clk) begin
        if (!rst_n || !in_frame) rai_status <= 1'b0;
        else if (alarm_ev)       rai_status <= rx_bit;
    end

    // Sticky loss flag and its gated interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lof_sticky <= 1'b0;
            irq_lof    <= 1'b0;
        end else begin
            if (lost_ev)              lof_sticky <= 1'b1;
            else if (flag_clr)        lof_sticky <= 1'b0;
            if (lost_ev && lof_ien)   irq_lof    <= 1'b1;
            else if (flag_clr)        irq_lof    <= 1'b0;
        end
    end

    // Gated far-end alarm interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n)                           irq_rai <= 1'b0;
        else if (alarm_ev && rx_bit && rai_ien) irq_rai <= 1'b1;
        else if (flag_clr)                    irq_rai <= 1'b0;
    end

    // R6: the alarm interrupt only rises with its enable set.
    p_rai_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_rai) |-> $past(rai_ien));

    // R7: the loss interrupt only rises with its enable set.
    p_lof_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_lof) |-> ($past(lof_ien) && lof_sticky));
endmodule

// File: rtl/fam_monitor.sv
// Frame alignment monitor top.
// Joins the word detector, alignment FSM, error counter and alarm flags.
// Assumes one valid line bit on every clock.
module fam_monitor
    import fam_pkg::*;
#(
    parameter int unsigned        FRAME_LEN  = 2928,
    parameter int unsigned        FAW_LEN    = FAW_BITS,
    parameter logic [FAW_LEN-1:0] FAW_WORD   = FAW_DEFAULT,
    parameter int unsigned        GAIN_WORDS = 3,
    parameter int unsigned        LOSS_WORDS = 4,
    parameter int unsigned        CNT_W      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             mon_dis,
    input  logic             lof_ien,
    input  logic             rai_ien,
    input  logic             flag_clr,
    input  logic             err_clr,
    output logic             in_frame,
    output logic             rai_status,
    output logic             lof_sticky,
    output logic             irq_lof,
    output logic             irq_rai,
    output logic [CNT_W-1:0] err_cnt
);
    logic match;
    logic err_ev;
    logic lost_ev;
    logic alarm_ev;

    fam_faw_detect #(.FAW_LEN(FAW_LEN), .FAW_WORD(FAW_WORD)) u_det (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .match(match)
    );

    fam_align_fsm #(
        .FRAME_LEN(FRAME_LEN), .FAW_LEN(FAW_LEN),
        .GAIN_WORDS(GAIN_WORDS), .LOSS_WORDS(LOSS_WORDS)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .mon_dis(mon_dis), .match(match),
        .in_frame(in_frame), .err_ev(err_ev), .lost_ev(lost_ev),
        .alarm_ev(alarm_ev)
    );

    fam_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(err_ev), .clr(err_clr), .cnt(err_cnt)
    );

    fam_alarm_flags u_flags (
        .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .alarm_ev(alarm_ev),
        .rx_bit(rx_bit), .lost_ev(lost_ev), .lof_ien(lof_ien),
        .rai_ien(rai_ien), .flag_clr(flag_clr), .rai_status(rai_status),
        .lof_sticky(lof_sticky), .irq_lof(irq_lof), .irq_rai(irq_rai)
    );

    // R8: the counter is frozen while alignment is not held.
    p_count_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_frame && !err_clr) |=> $stable(err_cnt));

    // R10: nothing is flagged while the monitor is disabled.
    p_dis_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_dis && !lof_sticky) |=> !lof_sticky);
endmodule

// File: tb/fam_monitor_tb_top.sv
module fam_monitor_tb_top;
    localparam int FRAME_LEN = 2928;
    localparam int CW        = 3;
    localparam logic [11:0] FAW = 12'b1111_1010_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0;
    logic mon_dis = 1'b0;
    logic lof_ien = 1'b1;
    logic rai_ien = 1'b1;
    logic flag_clr = 1'b0;
    logic err_clr = 1'b0;
    logic in_frame, rai_status, lof_sticky, irq_lof, irq_rai;
    logic [CW-1:0] err_cnt;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fam_monitor #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .mon_dis(mon_dis),
        .lof_ien(lof_ien), .rai_ien(rai_ien), .flag_clr(flag_clr),
        .err_clr(err_clr), .in_frame(in_frame), .rai_status(rai_status),
        .lof_sticky(lof_sticky), .irq_lof(irq_lof), .irq_rai(irq_rai),
        .err_cnt(err_cnt)
    );

    // Vector: {faw_ok, alarm, exp_in_frame, exp_rai, exp_lof, exp_err[2:0]}
    localparam logic [7:0] VEC [0:14] = '{
        8'b10_000_000, 8'b10_000_000, 8'b10_100_000, 8'b11_110_000,
        8'b10_100_000, 8'b00_100_001, 8'b10_100_001, 8'b00_100_010,
        8'b00_100_011, 8'b00_100_100, 8'b00_001_101, 8'b10_001_101,
        8'b10_001_101, 8'b10_101_101, 8'b11_111_101
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One frame; clear strobes drop after the first bit. Ends 1 ns after
    // the edge that samples the last bit.
    task automatic send_frame(input bit ok, input bit al);
        for (int k = 0; k < FRAME_LEN; k++) begin
            @(negedge clk);
            if (k == 1) begin
                err_clr  = 1'b0;
                flag_clr = 1'b0;
            end
            if (k < 12)       rx_bit = (k == 0 && !ok) ? 1'b0 : FAW[11-k];
            else if (k == 12) rx_bit = al;
            else              rx_bit = 1'b0;
        end
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        rx_bit = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 in_frame", 16'(in_frame), 16'd0);
        chk("R1 err_cnt", 16'(err_cnt), 16'd0);
        chk("R1 lof_sticky", 16'(lof_sticky), 16'd0);
        chk("R1 irq", 16'({irq_lof, irq_rai, rai_status}), 16'd0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // Table walk: R2 search, R3 gain, R4 loss, R5 alarm, R8 counting
        for (int i = 0; i < 15; i++) begin
            send_frame(VEC[i][7], VEC[i][6]);
            chk("R3/R4 in_frame", 16'(in_frame), 16'(VEC[i][5]));
            chk("R5 rai_status", 16'(rai_status), 16'(VEC[i][4]));
            chk("R7 lof_sticky", 16'(lof_sticky), 16'(VEC[i][3]));
            chk("R8 err_cnt", 16'(err_cnt), 16'(VEC[i][2:0]));
        end
        chk("R6 irq_rai", 16'(irq_rai), 16'd1);
        chk("R7 irq_lof", 16'(irq_lof), 16'd1);

        // R1 reset from a busy state; R3 wrong word during confirmation
        do_reset();
        send_frame(1, 0);
        send_frame(0, 0);
        send_frame(1, 0);
        send_frame(1, 0);
        chk("R3 confirm restart", 16'(in_frame), 16'd0);
        chk("R8 no count out of frame", 16'(err_cnt), 16'd0);
        send_frame(1, 0);
        chk("R3 regained", 16'(in_frame), 16'd1);

        // R9 saturation with alignment held by runs of three errors
        for (int r = 0; r < 2; r++) begin
            send_frame(0, 0);
            send_frame(0, 0);
            send_frame(0, 0);
            send_frame(1, 0);
        end
        chk("R9 count before full", 16'(err_cnt), 16'd6);
        send_frame(0, 0);
        chk("R9 full", 16'(err_cnt), 16'd7);
        send_frame(1, 0);
        send_frame(0, 0);
        chk("R9 saturated", 16'(err_cnt), 16'd7);
        chk("R4 run reset keeps frame", 16'(in_frame), 16'd1);
        err_clr = 1'b1;
        send_frame(1, 0);
        chk("R9 cleared", 16'(err_cnt), 16'd0);

        // R10 disable: no search, no count, no flags
        flag_clr = 1'b1;
        mon_dis = 1'b1;
        send_frame(0, 1);
        chk("R10 out of frame", 16'(in_frame), 16'd0);
        send_frame(1, 0);
        send_frame(1, 0);
        chk("R10 no search", 16'(in_frame), 16'd0);
        chk("R10 no count", 16'(err_cnt), 16'd0);
        chk("R10 no flag", 16'({lof_sticky, irq_lof, irq_rai, rai_status}), 16'd0);
        mon_dis = 1'b0;
        send_frame(1, 0);
        send_frame(1, 0);
        send_frame(1, 0);
        chk("R10 fresh search", 16'(in_frame), 16'd1);

        // R6/R7 with interrupt enables low
        rai_ien = 1'b0;
        lof_ien = 1'b0;
        send_frame(1, 1);
        chk("R5 alarm seen", 16'(rai_status), 16'd1);
        chk("R6 gated irq_rai", 16'(irq_rai), 16'd0);
        for (int j = 0; j < 4; j++) send_frame(0, 0);
        chk("R4 lost", 16'(in_frame), 16'd0);
        chk("R7 sticky without enable", 16'(lof_sticky), 16'd1);
        chk("R7 gated irq_lof", 16'(irq_lof), 16'd0);
        chk("R8 loss word counted", 16'(err_cnt), 16'd4);
        chk("R5 cleared out of frame", 16'(rai_status), 16'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule